// File: doc/BRIEF.md
# Burst Write Bus Initiator

This block moves words from an on-chip producer onto a 32-bit multiplexed address/data parallel bus as memory-write bursts, for example to fill a frame buffer that sits on the far side of that bus. A producer hands it one transfer descriptor at a time: a byte start address and a word count. The words themselves arrive on a separate data stream. The block asks for the bus and waits for the grant. It then issues an address phase followed by up to 16 data phases per burst. It keeps issuing bursts back to back for as long as the grant stays low and words are pending. If the target stops a burst early, the block keeps the exact word position and restarts from it after a fixed idle gap. If no target claims the cycle, the block ends the burst, discards the rest of the descriptor's words and reports an error.

Both producer interfaces are valid/ready. A descriptor is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no descriptor is held, and also in the cycle the held descriptor retires. A data word is consumed on an edge where `wdata_valid` and `wdata_ready` are both high. `wdata` must stay stable while `wdata_valid` waits for `wdata_ready`. A producer that lowers `wdata_valid` only stretches the bus with IRDY# high. All bus control pins are active low. There is no locked-access or snoop support, so exclusive access to shared memory is left to software.

Top module: `pbus_burst_writer`

## Requirements
- R1: `req_ready` is high after reset and whenever no descriptor is held. A descriptor (word count of 1 or more) is taken on `req_valid && req_ready`. While a descriptor is held, `bus_req_n` is low, except while its words are being discarded after an abort.
- R2: In the address phase, `bus_frame_n` is low and `bus_irdy_n` is high. `bus_cbe_n` carries the memory-write command 4'b0111 and `bus_ad` carries the current byte address, with `bus_ad_oe` high.
- R3: In a data phase, `bus_cbe_n` is 4'b0000 (all bytes enabled) and `bus_ad` carries the head word of the data stream. A word moves only on an edge where `bus_irdy_n`, `bus_trdy_n` and `bus_devsel_n` are all low. That edge also consumes the word from the stream, and the bus address advances by 4 per word.
- R4: A burst has at most 16 data phases. `bus_frame_n` is high during the final data phase, and `bus_irdy_n` stays low until that phase completes. No data phase follows without a new address phase.
- R5: When a burst ends normally with `bus_gnt_n` low and words pending (in the same descriptor or in one waiting on `req_valid`), the next address phase comes in the very next cycle.
- R6: When `bus_stop_n` is sampled low in a data phase, the burst ends at that edge. The word counts as moved if `bus_trdy_n` was also low. The bus then idles exactly two cycles, and the address phase for the remaining words at the following address comes in the third cycle after the stop edge.
- R7: When `bus_gnt_n` is high during a data phase, that phase becomes the final one (`bus_frame_n` high). After it completes, the bus is released (`bus_ad_oe` low) while `bus_req_n` stays low. The remaining words continue at the correct address after the next grant.
- R8: If `bus_devsel_n` is not low in any of the first 5 data-phase cycles after an address phase, the burst ends. The descriptor's remaining words are taken from the data stream without any bus transfer, and the descriptor completes with an error.
- R9: `done_valid` pulses for exactly one cycle per descriptor: in the cycle after its last word moves (or is discarded). `done_err` is 1 for an aborted descriptor and 0 otherwise.
- R10: After reset, `bus_frame_n`, `bus_irdy_n` and `bus_req_n` are high, `bus_ad_oe` is low and `done_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Descriptor offered |
| req_ready | output | 1 | Descriptor can be taken |
| req_addr | input | 32 | Byte start address (word aligned) |
| req_words | input | 16 | Word count, 1 or more |
| wdata_valid | input | 1 | Data word offered |
| wdata_ready | output | 1 | Data word consumed this edge |
| wdata | input | 32 | Data word |
| done_valid | output | 1 | Descriptor finished (one-cycle pulse) |
| done_err | output | 1 | Finished descriptor was aborted |
| bus_req_n | output | 1 | Bus request, active low |
| bus_gnt_n | input | 1 | Bus grant, active low |
| bus_frame_n | output | 1 | Cycle frame, active low |
| bus_irdy_n | output | 1 | Initiator ready, active low |
| bus_cbe_n | output | 4 | Command / byte enables, active low |
| bus_ad | output | 32 | Address / data |
| bus_ad_oe | output | 1 | Drive enable for address, data, command and frame lines |
| bus_devsel_n | input | 1 | Target claims cycle, active low |
| bus_trdy_n | input | 1 | Target ready, active low |
| bus_stop_n | input | 1 | Target requests stop, active low |

## Verification
A wrong saved address or word count shows up on the first address phase after a disconnect or grant loss: the restart address is off, or the words after it repeat or skip. A scoreboard that pairs every bus word with its expected address catches either fault at that very word. A burst counter that is off by one shows up as a 15- or 17-beat burst, or as FRAME# rising at the wrong data phase, and the per-burst length log catches it at the end of the first long burst. Faults in the idle gap, the claim timeout or the completion timing show up in a cycle count between the stop edge and the restart, in an error flag on the wrong descriptor, or in a done pulse that is not exactly one cycle after the last word.

// File: rtl/pbw_pkg.sv
package pbw_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_DATA,
    S_GAP,
    S_DRAIN
  } pbw_state_e;

  localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;
  localparam logic [3:0] BE_ALL_BYTES  = 4'b0000;
  localparam logic [3:0] CBE_IDLE      = 4'b1111;

endpackage

// File: rtl/pbw_job.sv
module pbw_job #(
  parameter int BUS_W = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [BUS_W-1:0] ld_addr_i,
  input  logic [CNT_W-1:0] ld_count_i,
  input  logic             step_i,
  input  logic             err_set_i,
  input  logic             retire_i,
  output logic [BUS_W-1:0] addr_o,
  output logic [CNT_W-1:0] remain_o,
  output logic             err_o,
  output logic             active_o
);

  localparam logic [BUS_W-1:0] WORD_BYTES = BUS_W'(4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o   <= '0;
      remain_o <= '0;
      err_o    <= 1'b0;
      active_o <= 1'b0;
    end else if (load_i) begin
      addr_o   <= ld_addr_i;
      remain_o <= ld_count_i;
      err_o    <= 1'b0;
      active_o <= 1'b1;
    end else begin
      if (retire_i) active_o <= 1'b0;
      if (step_i) begin
        addr_o   <= addr_o + WORD_BYTES;
        remain_o <= remain_o - CNT_W'(1);
      end
      if (err_set_i) err_o <= 1'b1;
    end
  end

  AST_JOB_HAS_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (remain_o != '0)); // R3

endmodule

// File: rtl/pbw_seq.sv
module pbw_seq
  import pbw_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int BURST_LEN    = 16,
  parameter int DEVSEL_LIMIT = 5,
  parameter int RESTART_GAP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic [CNT_W-1:0] remain_i,
  input  logic             req_valid_i,
  input  logic             gnt_n_i,
  input  logic             devsel_n_i,
  input  logic             trdy_n_i,
  input  logic             stop_n_i,
  input  logic             wdata_valid_i,
  output pbw_state_e       state_o,
  output logic             last_o,
  output logic             xfer_o,
  output logic             step_o,
  output logic             retire_o,
  output logic             abort_o
);

  localparam int BL_W = $clog2(BURST_LEN + 1);
  localparam int DV_W = $clog2(DEVSEL_LIMIT + 1);
  localparam int GP_W = $clog2(RESTART_GAP + 1);
  localparam logic [BL_W-1:0] BURST_MAX  = BL_W'(BURST_LEN);
  localparam logic [DV_W-1:0] DEV_LASTCY = DV_W'(DEVSEL_LIMIT - 1);
  localparam logic [GP_W-1:0] GAP_LASTCY = GP_W'(RESTART_GAP - 1);

  pbw_state_e      state_q, state_d;
  logic [BL_W-1:0] burst_left_q;
  logic [DV_W-1:0] dev_cnt_q;
  logic            dev_seen_q;
  logic [GP_W-1:0] gap_cnt_q;
  logic            in_data, final_word, drain_take;

  assign in_data    = (state_q == S_DATA);
  assign final_word = (remain_i == CNT_W'(1));
  assign last_o     = in_data && ((burst_left_q == BL_W'(1)) || gnt_n_i);
  assign xfer_o     = in_data && wdata_valid_i && !trdy_n_i && !devsel_n_i;
  assign abort_o    = in_data && !dev_seen_q && devsel_n_i && (dev_cnt_q == DEV_LASTCY);
  assign drain_take = (state_q == S_DRAIN) && wdata_valid_i;
  assign step_o     = xfer_o || drain_take;
  assign retire_o   = step_o && final_word;
  assign state_o    = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (active_i && !gnt_n_i) state_d = S_ADDR;
      S_ADDR:  state_d = S_DATA;
      S_DATA: begin
        if (abort_o)                    state_d = S_DRAIN;
        else if (xfer_o && final_word)  state_d = (req_valid_i && !gnt_n_i && stop_n_i) ? S_ADDR : S_IDLE;
        else if (!stop_n_i)             state_d = S_GAP;
        else if (xfer_o && last_o)      state_d = gnt_n_i ? S_IDLE : S_ADDR;
      end
      S_GAP:   if (gap_cnt_q == GAP_LASTCY) state_d = gnt_n_i ? S_IDLE : S_ADDR;
      S_DRAIN: if (retire_o) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      burst_left_q <= '0;
      dev_cnt_q    <= '0;
      dev_seen_q   <= 1'b0;
      gap_cnt_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_ADDR) begin
        burst_left_q <= (remain_i < CNT_W'(BURST_LEN)) ? BL_W'(remain_i) : BURST_MAX;
        dev_cnt_q    <= '0;
        dev_seen_q   <= 1'b0;
      end else if (in_data) begin
        if (xfer_o) burst_left_q <= burst_left_q - BL_W'(1);
        if (!devsel_n_i)      dev_seen_q <= 1'b1;
        else if (!dev_seen_q) dev_cnt_q  <= dev_cnt_q + DV_W'(1);
      end
      if (state_q == S_GAP) gap_cnt_q <= gap_cnt_q + GP_W'(1);
      else                  gap_cnt_q <= '0;
    end
  end

  AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DATA) |-> (burst_left_q != '0 && burst_left_q <= BURST_MAX)); // R4

  AST_FINAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && last_o && !xfer_o && stop_n_i && !abort_o) |=> (state_q == S_DATA)); // R4

  AST_RESTART_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ADDR && $past(state_q) == S_GAP) |-> ($past(state_q, 2) == S_GAP)); // R6

  AST_DEVSEL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !dev_seen_q) |-> (dev_cnt_q <= DEV_LASTCY)); // R8

endmodule

// File: rtl/pbw_drive.sv
module pbw_drive
  import pbw_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  pbw_state_e       state_i,
  input  logic [BUS_W-1:0] addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic             last_i,
  input  logic             wdata_valid_i,
  output logic             frame_n_o,
  output logic             irdy_n_o,
  output logic [3:0]       cbe_n_o,
  output logic [BUS_W-1:0] ad_o,
  output logic             ad_oe_o
);

  always_comb begin
    frame_n_o = 1'b1;
    irdy_n_o  = 1'b1;
    cbe_n_o   = CBE_IDLE;
    ad_o      = '0;
    ad_oe_o   = 1'b0;
    unique case (state_i)
      S_ADDR: begin
        frame_n_o = 1'b0;
        cbe_n_o   = CMD_MEM_WRITE;
        ad_o      = addr_i;
        ad_oe_o   = 1'b1;
      end
      S_DATA: begin
        frame_n_o = last_i;
        irdy_n_o  = !wdata_valid_i;
        cbe_n_o   = BE_ALL_BYTES;
        ad_o      = wdata_i;
        ad_oe_o   = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pbus_burst_writer.sv
module pbus_burst_writer
  import pbw_pkg::*;
#(
  parameter int BUS_W        = 32,
  parameter int CNT_W        = 16,
  parameter int BURST_LEN    = 16,
  parameter int DEVSEL_LIMIT = 5,
  parameter int RESTART_GAP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [CNT_W-1:0] req_words,
  input  logic             wdata_valid,
  output logic             wdata_ready,
  input  logic [BUS_W-1:0] wdata,
  output logic             done_valid,
  output logic             done_err,
  output logic             bus_req_n,
  input  logic             bus_gnt_n,
  output logic             bus_frame_n,
  output logic             bus_irdy_n,
  output logic [3:0]       bus_cbe_n,
  output logic [BUS_W-1:0] bus_ad,
  output logic             bus_ad_oe,
  input  logic             bus_devsel_n,
  input  logic             bus_trdy_n,
  input  logic             bus_stop_n
);

  pbw_state_e       state;
  logic [BUS_W-1:0] job_addr;
  logic [CNT_W-1:0] job_remain;
  logic             job_err, job_active;
  logic             last, xfer, step, retire, abort, load;

  assign req_ready   = !job_active || retire;
  assign load        = req_valid && req_ready;
  assign wdata_ready = step;
  assign bus_req_n   = !(job_active && state != S_DRAIN);

  pbw_job #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_job (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .ld_addr_i  (req_addr),
    .ld_count_i (req_words),
    .step_i     (step),
    .err_set_i  (abort),
    .retire_i   (retire),
    .addr_o     (job_addr),
    .remain_o   (job_remain),
    .err_o      (job_err),
    .active_o   (job_active)
  );

  pbw_seq #(
    .CNT_W(CNT_W), .BURST_LEN(BURST_LEN),
    .DEVSEL_LIMIT(DEVSEL_LIMIT), .RESTART_GAP(RESTART_GAP)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .active_i      (job_active),
    .remain_i      (job_remain),
    .req_valid_i   (req_valid),
    .gnt_n_i       (bus_gnt_n),
    .devsel_n_i    (bus_devsel_n),
    .trdy_n_i      (bus_trdy_n),
    .stop_n_i      (bus_stop_n),
    .wdata_valid_i (wdata_valid),
    .state_o       (state),
    .last_o        (last),
    .xfer_o        (xfer),
    .step_o        (step),
    .retire_o      (retire),
    .abort_o       (abort)
  );

  pbw_drive #(.BUS_W(BUS_W)) u_drive (
    .state_i       (state),
    .addr_i        (job_addr),
    .wdata_i       (wdata),
    .last_i        (last),
    .wdata_valid_i (wdata_valid),
    .frame_n_o     (bus_frame_n),
    .irdy_n_o      (bus_irdy_n),
    .cbe_n_o       (bus_cbe_n),
    .ad_o          (bus_ad),
    .ad_oe_o       (bus_ad_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_valid <= 1'b0;
      done_err   <= 1'b0;
    end else begin
      done_valid <= retire;
      if (retire) done_err <= job_err || abort;
    end
  end

  AST_ACCEPT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> job_active); // R1

  AST_WORDS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_words != '0)); // R1

  AST_FRAME_NEEDS_JOB: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_frame_n |-> (job_active && !bus_req_n)); // R2

  AST_DATA_ONLY_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wdata_ready && bus_ad_oe) |-> (!bus_irdy_n && !bus_trdy_n && !bus_devsel_n)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R9

endmodule

// File: tb/pbus_burst_writer_tb.sv
module pbus_burst_writer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic [15:0] req_words = '0;
  logic        wdata_valid = 1'b0, wdata_ready;
  logic [31:0] wdata = '0;
  logic        done_valid, done_err;
  logic        bus_req_n, bus_gnt_n = 1'b1;
  logic        bus_frame_n, bus_irdy_n, bus_ad_oe;
  logic [3:0]  bus_cbe_n;
  logic [31:0] bus_ad;
  logic        bus_devsel_n = 1'b1, bus_trdy_n = 1'b1, bus_stop_n = 1'b1;

  always #4 clk = ~clk;  // 125 MHz

  pbus_burst_writer u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_words(req_words),
    .wdata_valid(wdata_valid), .wdata_ready(wdata_ready), .wdata(wdata),
    .done_valid(done_valid), .done_err(done_err),
    .bus_req_n(bus_req_n), .bus_gnt_n(bus_gnt_n), .bus_frame_n(bus_frame_n),
    .bus_irdy_n(bus_irdy_n), .bus_cbe_n(bus_cbe_n), .bus_ad(bus_ad), .bus_ad_oe(bus_ad_oe),
    .bus_devsel_n(bus_devsel_n), .bus_trdy_n(bus_trdy_n), .bus_stop_n(bus_stop_n)
  );

  typedef struct { logic [31:0] a; logic [31:0] d; bit lastw; } beat_t;
  typedef struct { logic [31:0] a; logic [15:0] n; } rq_t;

  beat_t       exp_q[$];
  logic [31:0] data_q[$];
  rq_t         req_q[$];
  bit          err_q[$];
  int          burst_log[$];

  int checks = 0, errors = 0;
  int cyc = 0, word_id = 0;
  int dev_delay = 1, trdy_alt = 0, stop_at = 0, drop_at = 0, drop_len = 0, drop_left = 0;
  bit in_burst = 0, expect_b2b = 0, expect_resume = 0, drop_idle_seen = 0, xf;
  int tcyc = 0, wb = 0, last_end_cyc = -1, stop_cyc = -1, last_word_cyc = -1;
  logic [31:0] cur_addr = '0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // driver: pushes stimulus and the expected scoreboard items
  task automatic run_req(input logic [31:0] a, input int n, input bit err);
    rq_t r;
    for (int i = 0; i < n; i++) begin
      beat_t b;
      logic [31:0] d;
      d = 32'h5A00_0000 + 32'(word_id) * 32'h0001_0103;
      word_id++;
      data_q.push_back(d);
      if (!err) begin
        b.a = a + 32'(4 * i);
        b.d = d;
        b.lastw = (i == n - 1);
        exp_q.push_back(b);
      end
    end
    r.a = a;
    r.n = 16'(n);
    req_q.push_back(r);
    err_q.push_back(err);
  endtask

  task automatic wait_idle();
    while (req_q.size() != 0 || exp_q.size() != 0 || err_q.size() != 0 || data_q.size() != 0)
      @(posedge clk);
    repeat (4) @(posedge clk);
  endtask

  task automatic chk_log(input string rq, input int n, input int l0, input int l1, input int l2);
    int want[3];
    want[0] = l0; want[1] = l1; want[2] = l2;
    chk(burst_log.size() == n, rq, "burst count", 32'(burst_log.size()), 32'(n));
    for (int i = 0; i < n && i < burst_log.size(); i++)
      chk(burst_log[i] == want[i], rq, "burst length", 32'(burst_log[i]), 32'(want[i]));
    burst_log.delete();
  endtask

  // bus target, arbiter, producer and monitor: drive at negedge, sample 1 ns before posedge
  always begin
    @(negedge clk);
    req_valid = (req_q.size() != 0);
    if (req_q.size() != 0) begin req_addr = req_q[0].a; req_words = req_q[0].n; end
    wdata_valid = (data_q.size() != 0);
    if (data_q.size() != 0) wdata = data_q[0];
    bus_devsel_n = !(in_burst && (tcyc + 1) >= dev_delay);
    bus_trdy_n   = !(in_burst && (tcyc + 1) >= dev_delay && (trdy_alt == 0 || ((tcyc + 1) % 2) == 0));
    bus_stop_n   = !(in_burst && stop_at != 0 && (wb + 1) == stop_at && !bus_trdy_n);
    if (drop_left > 0) begin bus_gnt_n = 1'b1; drop_left--; end
    else bus_gnt_n = 1'b0;
    #3;
    if (rst_n) begin
      cyc++;
      if (req_valid && req_ready) void'(req_q.pop_front());
      if (wdata_ready) begin
        chk(wdata_valid, "R3", "ready without valid", 32'(wdata_ready), 32'(wdata_valid));
        if (data_q.size() != 0) void'(data_q.pop_front());
      end
      if (done_valid) begin
        if (err_q.size() == 0) chk(0, "R9", "unexpected done", 1, 0);
        else begin
          bit e;
          e = err_q.pop_front();
          chk(done_err == e, "R9", "done_err", 32'(done_err), 32'(e));
          if (!e) chk(cyc == last_word_cyc + 1, "R9", "done timing", 32'(cyc), 32'(last_word_cyc + 1));
        end
      end
      if (bus_gnt_n && in_burst && bus_ad_oe && !bus_irdy_n)
        chk(bus_frame_n == 1'b1, "R7", "frame on grant loss", 32'(bus_frame_n), 1);
      if (bus_gnt_n && !in_burst && !drop_idle_seen && drop_len != 0) begin
        chk(!bus_ad_oe && !bus_req_n, "R7", "release keeps request",
            {30'd0, bus_ad_oe, bus_req_n}, 0);
        drop_idle_seen = 1;
      end
      if (bus_ad_oe && !bus_frame_n && bus_irdy_n) begin
        chk(bus_cbe_n == 4'b0111, "R2", "address command", 32'(bus_cbe_n), 32'h7);
        if (expect_b2b && last_end_cyc >= 0) begin
          chk(cyc == last_end_cyc + 1, "R5", "back-to-back", 32'(cyc), 32'(last_end_cyc + 1));
          last_end_cyc = -1;
        end
        if (expect_resume && stop_cyc >= 0) begin
          chk(cyc == stop_cyc + 3, "R6", "restart gap", 32'(cyc), 32'(stop_cyc + 3));
          expect_resume = 0;
          stop_cyc = -1;
        end
        in_burst = 1; tcyc = 0; wb = 0; cur_addr = bus_ad;
      end else if (in_burst) begin
        tcyc++;
        if (!bus_ad_oe) in_burst = 0;
        else begin
          xf = !bus_irdy_n && !bus_trdy_n && !bus_devsel_n;
          if (xf) begin
            chk(bus_cbe_n == 4'b0000, "R3", "byte enables", 32'(bus_cbe_n), 0);
            if (exp_q.size() == 0) chk(0, "R3", "unexpected word", bus_ad, 0);
            else begin
              beat_t b;
              b = exp_q.pop_front();
              chk(cur_addr == b.a, "R3", "word address", cur_addr, b.a);
              chk(bus_ad == b.d, "R3", "word data", bus_ad, b.d);
              if (b.lastw) last_word_cyc = cyc;
            end
            wb++;
            cur_addr += 4;
            if (drop_at != 0 && wb == drop_at) begin drop_left = drop_len; drop_at = 0; end
          end
          if (!bus_stop_n) begin
            stop_cyc = cyc; stop_at = 0; in_burst = 0;
          end else if (xf && bus_frame_n) begin
            burst_log.push_back(wb);
            chk(wb <= 16, "R4", "burst too long", 32'(wb), 16);
            last_end_cyc = cyc;
            in_burst = 0;
          end
        end
      end else if (bus_ad_oe && !bus_irdy_n) begin
        chk(0, "R4", "data phase without address", bus_ad, 0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #3;
    // R10 reset state
    chk(bus_frame_n && bus_irdy_n && bus_req_n, "R10", "idle controls",
        {29'd0, bus_frame_n, bus_irdy_n, bus_req_n}, 7);
    chk(!bus_ad_oe && !done_valid, "R10", "no drive, no done", {30'd0, bus_ad_oe, done_valid}, 0);
    chk(req_ready == 1'b1, "R1", "ready when empty", 32'(req_ready), 1);
    @(posedge clk);

    // R1 R2 R3: single short descriptor
    run_req(32'h1000_0000, 5, 0);
    wait_idle();
    chk_log("R4", 1, 5, 0, 0);

    // R4 R5: long descriptor split into 16,16,8 with back-to-back bursts
    expect_b2b = 1; last_end_cyc = -1;
    run_req(32'h2000_0100, 40, 0);
    wait_idle();
    chk_log("R4", 3, 16, 16, 8);

    // R5: two queued descriptors chain without release
    last_end_cyc = -1;
    run_req(32'h3000_0000, 3, 0);
    run_req(32'h3100_0040, 4, 0);
    wait_idle();
    chk_log("R5", 2, 3, 4, 0);
    expect_b2b = 0;

    // R6: disconnect on 7th word, restart after two idle cycles
    stop_at = 7; expect_resume = 1; stop_cyc = -1;
    run_req(32'h4000_0000, 20, 0);
    wait_idle();
    chk(expect_resume == 0, "R6", "restart seen", 32'(expect_resume), 0);
    chk_log("R6", 1, 13, 0, 0);

    // R3: slow claim and target wait states
    dev_delay = 3; trdy_alt = 1;
    run_req(32'h5000_0000, 10, 0);
    wait_idle();
    chk_log("R3", 1, 10, 0, 0);
    dev_delay = 1; trdy_alt = 0;

    // R7: grant removed after 4th word
    drop_at = 4; drop_len = 3; drop_idle_seen = 0;
    run_req(32'h6000_0000, 12, 0);
    wait_idle();
    chk(drop_idle_seen == 1, "R7", "release observed", 32'(drop_idle_seen), 1);
    chk_log("R7", 2, 5, 7, 0);
    drop_len = 0;

    // R8: no claim within 5 cycles -> abort with error, words drained
    dev_delay = 6;
    run_req(32'h7000_0000, 6, 1);
    wait_idle();
    chk_log("R8", 0, 0, 0, 0);
    // R8 boundary: claim in the 5th cycle succeeds
    dev_delay = 5;
    run_req(32'h7100_0000, 3, 0);
    wait_idle();
    chk_log("R8", 1, 3, 0, 0);
    dev_delay = 1;

    // R4 boundary: exactly 16 words in one burst
    run_req(32'h8000_0000, 16, 0);
    wait_idle();
    chk_log("R4", 1, 16, 0, 0);
    chk(!bus_ad_oe && bus_req_n, "R1", "idle after all work", {30'd0, bus_ad_oe, bus_req_n}, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule